// File: doc/BRIEF.md
# EEPROM Page Write Sequencer

This block sits behind the serial-bus decoder of a byte-addressable nonvolatile memory. It gathers the data bytes of one write transaction into a page-sized buffer. When the transaction closes, it copies them into the storage array during a timed internal write cycle. The decoder gives it a write-start event carrying the two-byte word address, one strobe per received data byte, and the STOP event. The sequencer supplies the busy flag, which the decoder uses to withhold acknowledges, a synchronous byte write port towards the array, and the current-address value that a later current-address read starts from.

The upper address bits select the page and stay fixed for the whole transaction. The lower bits are an offset that advances after each byte and wraps inside the page. The commit runs once per transaction. It walks the page in ascending offset order and writes only the locations that received a byte. A write-protect input, held high from the start event through STOP, suppresses the commit. The bytes are still taken, and the address still advances. The length of the write cycle is a parameter counted in clock cycles.

Top module: `pgw_seq`

## Requirements
- R1: When `busy_o` is low, a `start_i` pulse is accepted, and on the following cycle `cur_addr_o` equals `start_addr_i`.
- R2: Each committed byte is written at address {start address bits above the offset, offset}. The offset is the start offset plus the number of earlier bytes in the transaction, taken modulo the page size of 2^PAGE_W bytes. When the offset wraps, the byte last received for a location is the one written.
- R3: A `stop_i` pulse after at least one data byte raises `busy_o` on the next cycle and holds it for exactly WR_CYCLES cycles.
- R4: While `busy_o` is high, `start_i`, `byte_vld_i` and `stop_i` are ignored. `cur_addr_o` does not change, and no extra write or busy window results.
- R5: A `stop_i` pulse with no data byte since the accepted start leaves `busy_o` low, produces no write, and keeps `cur_addr_o` at the start address.
- R6: The commit issues exactly one write per page location that received a byte, in strictly ascending offset order, and all of them fall inside the busy window. Locations that received no byte are not written.
- R7: After STOP, `cur_addr_o` is the start address with its offset advanced by the byte count (modulo the page size) when the count is between 1 and 2^PAGE_W−1. It is the start address itself when the count is 2^PAGE_W or more. A single byte at the last offset therefore gives offset 0 of the same page.
- R8: If `wp_i` is high in the start cycle and in every cycle up to and including the STOP cycle, the commit issues no write. If `wp_i` is low in any of those cycles, the commit proceeds normally. `cur_addr_o` follows R7 in both cases.
- R9: A `start_i` that arrives before STOP discards the bytes received so far, and the new transaction starts from its own address.
- R10: After reset, `busy_o` and `mem_we_o` are low and `cur_addr_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Write transaction start event, one cycle |
| start_addr_i | input | ADDR_W | Word address supplied with the start event |
| byte_vld_i | input | 1 | Data byte strobe, one cycle per byte |
| byte_i | input | DATA_W | Data byte |
| stop_i | input | 1 | STOP event, one cycle |
| wp_i | input | 1 | Write protect, high blocks the commit |
| busy_o | output | 1 | Internal write cycle in progress |
| mem_we_o | output | 1 | Array write enable |
| mem_addr_o | output | ADDR_W | Array write address |
| mem_wdata_o | output | DATA_W | Array write data |
| cur_addr_o | output | ADDR_W | Current address after the last access |

## Verification
The bench sweeps every start offset in a page with a range of byte counts, then aims at the edges: one byte at the last offset, a wrap from offset 126, exactly a full page, and more than a full page. A design that wrapped across the page boundary would write into the next page. Advancing the address by the raw count, or forgetting the full-page rule, would leave a wrong current address. Committing stale buffer entries would write locations the transaction never touched. Further cases cover an empty STOP, which must not open a busy window, commands sent during busy, which a broken design would act on, protection dropped for a single byte cycle, which a design sampling only at START would wrongly honour, and a restart in mid-transaction, which must not leak the abandoned bytes.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RECV = 2'd1,
    ST_BUSY = 2'd2
  } pgw_state_e;

  // Address left behind by a write of cnt bytes starting at addr,
  // with pages of 2**page_w bytes.
  function automatic int unsigned pgw_next_addr(input int unsigned addr,
                                                input int unsigned cnt,
                                                input int unsigned page_w);
    int unsigned pmask;
    pmask = (32'd1 << page_w) - 32'd1;
    if (cnt > pmask) return addr;
    return (addr & ~pmask) | ((addr + cnt) & pmask);
  endfunction

endpackage

// File: rtl/pgw_page_buf.sv
module pgw_page_buf #(
  parameter int PAGE_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [PAGE_W-1:0] wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [PAGE_W-1:0] rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_vld_o
);
  localparam int DEPTH = 1 << PAGE_W;

  logic [DATA_W-1:0] dat_w [DEPTH];
  logic [DEPTH-1:0]  vld_w;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic              v_q;
    logic [DATA_W-1:0] d_q;
    logic              hit;
    assign hit = wr_i && (wr_idx_i == PAGE_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     v_q <= 1'b0;
      else if (clr_i) v_q <= 1'b0;
      else if (hit)   v_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (hit) d_q <= wr_data_i;
    end

    assign dat_w[g] = d_q;
    assign vld_w[g] = v_q;
  end

  assign rd_data_o = dat_w[rd_idx_i];
  assign rd_vld_o  = vld_w[rd_idx_i];
endmodule

// File: rtl/pgw_wtimer.sv
module pgw_wtimer #(
  parameter int WR_CYCLES = 625000,
  parameter int CNT_W     = $clog2(WR_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_i,
  input  logic             run_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (go_i)   cnt_q <= '0;
    else if (run_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q == CNT_W'(WR_CYCLES - 1));
endmodule

// File: rtl/pgw_seq.sv
module pgw_seq #(
  parameter int ADDR_W    = 16,
  parameter int PAGE_W    = 7,
  parameter int DATA_W    = 8,
  parameter int WR_CYCLES = 625000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              byte_vld_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              stop_i,
  input  logic              wp_i,
  output logic              busy_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic [ADDR_W-1:0] cur_addr_o
);
  import pgw_pkg::*;

  localparam int PAGE  = 1 << PAGE_W;
  localparam int CNT_W = $clog2(WR_CYCLES + 1);

  pgw_state_e        state_q;
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] cur_q;
  logic [PAGE_W-1:0] off_q;
  logic [PAGE_W:0]   cnt_q;
  logic              wp_q;

  // named events, also observed by the checker
  logic start_acc, byte_acc, stop_commit, stop_empty, scan_on;
  logic [CNT_W-1:0]  tmr;
  logic              tmr_last;
  logic [PAGE_W-1:0] scan_idx;
  logic [DATA_W-1:0] buf_rd;
  logic              buf_vld;

  assign start_acc   = start_i && (state_q != ST_BUSY);
  assign byte_acc    = (state_q == ST_RECV) && byte_vld_i && !stop_i && !start_i;
  assign stop_commit = (state_q == ST_RECV) && stop_i && !start_i && (cnt_q != '0);
  assign stop_empty  = (state_q == ST_RECV) && stop_i && !start_i && (cnt_q == '0);
  assign busy_o      = (state_q == ST_BUSY);
  assign scan_on     = busy_o && (32'(tmr) < PAGE);
  assign scan_idx    = tmr[PAGE_W-1:0];

  pgw_page_buf #(.PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (start_acc),
    .wr_i     (byte_acc),
    .wr_idx_i (off_q),
    .wr_data_i(byte_i),
    .rd_idx_i (scan_idx),
    .rd_data_o(buf_rd),
    .rd_vld_o (buf_vld)
  );

  pgw_wtimer #(.WR_CYCLES(WR_CYCLES), .CNT_W(CNT_W)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .go_i  (stop_commit),
    .run_i (busy_o),
    .cnt_o (tmr),
    .last_o(tmr_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      base_q  <= '0;
      cur_q   <= '0;
      off_q   <= '0;
      cnt_q   <= '0;
      wp_q    <= 1'b0;
    end else if (start_acc) begin
      state_q <= ST_RECV;
      base_q  <= start_addr_i;
      cur_q   <= start_addr_i;
      off_q   <= start_addr_i[PAGE_W-1:0];
      cnt_q   <= '0;
      wp_q    <= wp_i;
    end else begin
      case (state_q)
        ST_RECV: begin
          wp_q <= wp_q & wp_i;
          if (stop_commit) begin
            state_q <= ST_BUSY;
            cur_q   <= ADDR_W'(pgw_next_addr(32'(base_q), 32'(cnt_q), PAGE_W));
          end else if (stop_empty) begin
            state_q <= ST_IDLE;
          end else if (byte_acc) begin
            off_q <= off_q + 1'b1;
            if (32'(cnt_q) < PAGE) cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_BUSY: if (tmr_last) state_q <= ST_IDLE;
        default: ;
      endcase
    end
  end

  assign mem_we_o    = scan_on && buf_vld && !wp_q;
  assign mem_addr_o  = {base_q[ADDR_W-1:PAGE_W], scan_idx};
  assign mem_wdata_o = buf_rd;
  assign cur_addr_o  = cur_q;
endmodule

// File: rtl/pgw_chk.sv
module pgw_chk #(
  parameter int ADDR_W    = 16,
  parameter int PAGE_W    = 7,
  parameter int WR_CYCLES = 625000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_acc,
  input logic              stop_commit,
  input logic              stop_empty,
  input logic              wp_i,
  input logic              busy_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [ADDR_W-1:0] cur_addr_o
);
  logic [31:0]       blen_q;
  logic              wp_trk_q;
  logic              have_prev_q;
  logic [ADDR_W-1:0] prev_addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blen_q      <= '0;
      wp_trk_q    <= 1'b0;
      have_prev_q <= 1'b0;
      prev_addr_q <= '0;
    end else begin
      blen_q <= busy_o ? blen_q + 32'd1 : 32'd0;
      if (start_acc)    wp_trk_q <= wp_i;
      else if (!busy_o) wp_trk_q <= wp_trk_q & wp_i;
      if (!busy_o) have_prev_q <= 1'b0;
      else if (mem_we_o) begin
        have_prev_q <= 1'b1;
        prev_addr_q <= mem_addr_o;
      end
    end
  end

  AST_BUSY_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    stop_commit |=> busy_o); // R3
  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (blen_q == 32'(WR_CYCLES))); // R3
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(cur_addr_o)); // R4
  AST_EMPTY_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    stop_empty |=> !busy_o); // R5
  AST_WE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> busy_o); // R6
  AST_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_o && have_prev_q) |->
      ((mem_addr_o[ADDR_W-1:PAGE_W] == prev_addr_q[ADDR_W-1:PAGE_W]) &&
       (mem_addr_o[PAGE_W-1:0] > prev_addr_q[PAGE_W-1:0]))); // R6
  AST_WP_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> !wp_trk_q); // R8
endmodule

bind pgw_seq pgw_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_acc  (start_acc),
  .stop_commit(stop_commit),
  .stop_empty (stop_empty),
  .wp_i       (wp_i),
  .busy_o     (busy_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o),
  .cur_addr_o (cur_addr_o)
);

// File: tb/test_pgw_seq.sv
module test_pgw_seq;
  localparam int WR = 200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] start_addr_i = '0;
  logic        byte_vld_i = 1'b0;
  logic [7:0]  byte_i = '0;
  logic        stop_i = 1'b0;
  logic        wp_i = 1'b0;
  logic        busy_o, mem_we_o;
  logic [15:0] mem_addr_o, cur_addr_o;
  logic [7:0]  mem_wdata_o;

  always #4 clk = ~clk;

  pgw_seq #(.ADDR_W(16), .PAGE_W(7), .DATA_W(8), .WR_CYCLES(WR)) i_pgw_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
    .byte_vld_i(byte_vld_i), .byte_i(byte_i), .stop_i(stop_i), .wp_i(wp_i),
    .busy_o(busy_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .cur_addr_o(cur_addr_o)
  );

  int n_chk = 0;
  int n_err = 0;
  int last_wr = 0;
  logic [15:0] cap_a[$];
  logic [7:0]  cap_d[$];
  logic [7:0]  e_val[128];
  bit          e_set[128];

  always @(negedge clk) begin
    if (rst_n && mem_we_o) begin
      cap_a.push_back(mem_addr_o);
      cap_d.push_back(mem_wdata_o);
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] dgen(input int s, input int i);
    return 8'((s * 37 + i * 11 + 5) & 255);
  endfunction

  // one transaction: start, n bytes, stop, then the whole busy window
  task automatic txn(input logic [15:0] a, input int n, input int seed,
                     input bit wp, input int drop_at, input bit inject);
    logic [15:0] exp_cur;
    int c, k, nexp;
    bit blocked;
    for (int o = 0; o < 128; o++) e_set[o] = 1'b0;
    cap_a.delete(); cap_d.delete();
    @(negedge clk);
    start_i = 1'b1; start_addr_i = a; wp_i = wp;
    @(negedge clk);
    start_i = 1'b0;
    chk(cur_addr_o == a, "R1", "cur after start", int'(cur_addr_o), int'(a));
    for (int i = 0; i < n; i++) begin
      int off;
      byte_vld_i = 1'b1;
      byte_i = dgen(seed, i);
      wp_i = (i == drop_at) ? 1'b0 : wp;
      off = (int'(a[6:0]) + i) % 128;
      e_val[off] = byte_i;
      e_set[off] = 1'b1;
      @(negedge clk);
    end
    byte_vld_i = 1'b0; wp_i = wp; stop_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b0;
    if (n == 0 || n >= 128) exp_cur = a;
    else exp_cur = {a[15:7], 7'((int'(a[6:0]) + n) % 128)};
    if (n == 0) begin
      chk(!busy_o, "R5", "busy after empty stop", int'(busy_o), 0);
      repeat (5) @(negedge clk);
      chk(!busy_o, "R5", "busy later", int'(busy_o), 0);
      chk(cap_a.size() == 0, "R5", "writes", cap_a.size(), 0);
      chk(cur_addr_o == a, "R5", "cur", int'(cur_addr_o), int'(a));
    end else begin
      chk(busy_o, "R3", "busy after stop", int'(busy_o), 1);
      chk(cur_addr_o == exp_cur, "R7", "cur after stop", int'(cur_addr_o), int'(exp_cur));
      c = 0;
      while (busy_o && c < WR + 50) begin
        c++;
        if (inject) begin
          start_i    = (c == 10);
          start_addr_i = 16'hBEEF;
          byte_vld_i = (c == 11);
          stop_i     = (c == 12);
        end
        @(negedge clk);
      end
      start_i = 1'b0; byte_vld_i = 1'b0; stop_i = 1'b0;
      chk(c == WR, "R3", "busy length", c, WR);
      blocked = wp && (drop_at < 0);
      nexp = 0;
      for (int o = 0; o < 128; o++) if (e_set[o]) nexp++;
      if (blocked) nexp = 0;
      chk(cap_a.size() == nexp, blocked ? "R8" : "R6", "write count", cap_a.size(), nexp);
      if (!blocked && cap_a.size() == nexp) begin
        k = 0;
        for (int o = 0; o < 128; o++) begin
          if (e_set[o]) begin
            logic [15:0] ea;
            ea = {a[15:7], 7'(o)};
            chk(cap_a[k] == ea, "R2", "write addr", int'(cap_a[k]), int'(ea));
            chk(cap_d[k] == e_val[o], "R2", "write data", int'(cap_d[k]), int'(e_val[o]));
            k++;
          end
        end
      end
      if (inject) begin
        repeat (3) @(negedge clk);
        chk(!busy_o, "R4", "busy after ignored cmds", int'(busy_o), 0);
        chk(cur_addr_o == exp_cur, "R4", "cur after ignored cmds", int'(cur_addr_o), int'(exp_cur));
        chk(cap_a.size() == nexp, "R4", "no extra writes", cap_a.size(), nexp);
      end
    end
    last_wr = cap_a.size();
    wp_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o, "R10", "busy at reset", int'(busy_o), 0);
    chk(!mem_we_o, "R10", "we at reset", int'(mem_we_o), 0);
    chk(cur_addr_o == 16'h0, "R10", "cur at reset", int'(cur_addr_o), 0);

    txn(16'h1200, 1, 1, 1'b0, -1, 1'b0);            // R2 single byte
    txn(16'h347F, 1, 2, 1'b0, -1, 1'b0);            // R7 last offset -> 0
    txn(16'h567E, 3, 3, 1'b0, -1, 1'b0);            // R2 wrap
    txn(16'h0A28, 128, 4, 1'b0, -1, 1'b0);          // R7 full page
    txn(16'h7764, 130, 5, 1'b0, -1, 1'b0);          // R2 overwrite
    txn(16'h2345, 0, 6, 1'b0, -1, 1'b0);            // R5 empty stop
    txn(16'h4410, 4, 7, 1'b1, -1, 1'b0);            // R8 protected
    chk(cur_addr_o == 16'h4414, "R8", "cur under wp", int'(cur_addr_o), 16'h4414);
    txn(16'h4410, 4, 8, 1'b1, 2, 1'b0);             // R8 wp dropped
    txn(16'h6020, 5, 9, 1'b0, -1, 1'b1);            // R4 commands during busy

    // R9: restart in mid-transaction
    @(negedge clk);
    start_i = 1'b1; start_addr_i = 16'h1111;
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 0; i < 3; i++) begin
      byte_vld_i = 1'b1; byte_i = 8'hA0 + 8'(i);
      @(negedge clk);
    end
    byte_vld_i = 1'b0;
    txn(16'h2290, 2, 10, 1'b0, -1, 1'b0);
    chk(last_wr == 2, "R9", "only new bytes", last_wr, 2);

    // sweep of every start offset with varied lengths
    for (int off = 0; off < 128; off++) begin
      logic [15:0] a;
      a = {9'(off * 3 + 1), 7'(off)};
      txn(a, 1 + (off * 7) % 19, 20 + off, 1'b0, -1, 1'b0);
    end

    finish_run();
  end
endmodule